// File: doc/BRIEF.md
# Unified Translation Cache with Pinned Entries

This block caches virtual-to-physical page translations for both instruction and data accesses in one shared structure. The structure has two regions. The main region is set-associative: two ways by sixteen sets, indexed by the low four bits of the virtual page number and tagged with the full 20-bit page number. The pinned region is fully associative and has eight entries. A page walker outside the block delivers fills. Lookups return a hit flag, a physical page number and an attribute byte one clock after the request.

Software steers fills through a small control register. The register holds a pin flag and a 3-bit slot index. While the pin flag is clear, fills go to the main region. The main region replaces entries round-robin within each set. While the pin flag is set, fills overwrite the pinned slot named by the index. A flush-all command empties only the main region, so pinned translations survive it. A flush-one command removes the matching page from both regions. This lets critical mappings stay resident until software releases them one by one.

Top module: `tlb_lockdown`

## Requirements
- R1: After reset every entry in both regions is invalid, `respValid` is 0, and the control register holds pin flag 0 with slot 0.
- R2: A lookup presented with `lookupValid` at clock edge k produces `respValid`=1 after edge k. `respHit`, `respPpn` and `respAttr` reflect the contents written by edges before k. A page filled at edge k-1 hits a lookup at edge k.
- R3: A main-region fill of a page not already in the set writes the way chosen by that set's round-robin pointer. The pointer then advances, so the third distinct page filled into a set evicts the first. Each set has its own pointer.
- R4: A main-region fill of a page already resident in its set overwrites that way. No other entry is evicted.
- R5: A fill made while the pin flag is set writes pinned slot `cfgData[2:0]`. Writing a slot again replaces the page it held.
- R6: `invAll` clears every main-region entry and leaves every pinned entry valid.
- R7: `invOne` removes the entry whose tag equals `invVpn` from both regions.
- R8: When a page hits in both regions, the response carries the pinned entry's physical page and attributes.
- R9: On a miss, `respPpn` and `respAttr` are zero.
- R10: A fill presented in the same cycle as `invAll` or `invOne` is dropped.
- R11: `cfgWrite` loads `cfgData`: bit 3 is the pin flag and bits 2:0 are the slot index. The new value governs fills from the next cycle on. With the pin flag clear, fills go only to the main region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | Lookup request |
| lookupVpn | input | 20 | Virtual page to translate |
| fillValid | input | 1 | Page-walk result available |
| fillVpn | input | 20 | Virtual page of the fill |
| fillPpn | input | 20 | Physical page of the fill |
| fillAttr | input | 8 | Attributes of the fill |
| cfgWrite | input | 1 | Write strobe for the placement register |
| cfgData | input | 4 | Bit 3 pin flag, bits 2:0 pinned slot |
| invAll | input | 1 | Flush the main region |
| invOne | input | 1 | Flush the entry matching `invVpn` in both regions |
| invVpn | input | 20 | Page to flush |
| respValid | output | 1 | Response valid, one cycle after a lookup |
| respHit | output | 1 | Translation found |
| respPpn | output | 20 | Physical page on a hit, zero otherwise |
| respAttr | output | 8 | Attributes on a hit, zero otherwise |

## Verification
Corrupt state in this block shows up only through later lookups. Either the next lookup to the affected page reports the wrong hit or page, or a different page of the same set goes missing. A bad replacement pointer or a bad pin steering therefore appears one or two fills later, not at once. The sequences are built so each fault becomes visible: they fill a set past its capacity, and they refill a resident page and then probe its neighbour. They also flush everything and probe pinned pages, and they place the same page in both regions. Together these turn a wrong victim, a lost pinned entry or a wrong priority into a wrong response on the following cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int TLB_VPN_W  = 20;
  localparam int TLB_PPN_W  = 20;
  localparam int TLB_ATTR_W = 8;
  localparam int TLB_SETS   = 16;
  localparam int TLB_WAYS   = 2;
  localparam int TLB_LOCK_N = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAll;   // flush main region
    logic clrOne;   // flush matching entry in both regions
    logic mainWr;   // write a main-region way
    logic lockWr;   // write a pinned slot
  } tlbStrobe_t;
endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int SETS   = TLB_SETS,
  parameter int WAYS   = TLB_WAYS,
  parameter int LOCK_N = TLB_LOCK_N,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int LOCK_W = $clog2(LOCK_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fillValid,
  input  logic [SET_W-1:0]  fillSet,
  input  logic              invAll,
  input  logic              invOne,
  input  logic              cfgWrite,
  input  logic [LOCK_W:0]   cfgData,
  input  logic              fillResident,
  input  logic [WAY_W-1:0]  fillResidentWay,
  output tlbStrobe_t        strobe,
  output logic [WAY_W-1:0]  fillWay,
  output logic [LOCK_W-1:0] lockIdx
);
  logic             pinFlag;
  logic [WAY_W-1:0] rrPtr [SETS];
  logic             fillOk;

  // R10: any flush in the same cycle drops the fill
  assign fillOk        = fillValid && !invAll && !invOne;
  assign strobe.clrAll = invAll;
  assign strobe.clrOne = invOne;
  assign strobe.mainWr = fillOk && !pinFlag;
  assign strobe.lockWr = fillOk && pinFlag;

  // R4: reuse the resident way, else R3: round-robin victim
  assign fillWay = fillResident ? fillResidentWay : rrPtr[fillSet];

  // R11: placement register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinFlag <= 1'b0;
      lockIdx <= '0;
    end else if (cfgWrite) begin
      pinFlag <= cfgData[LOCK_W];
      lockIdx <= cfgData[LOCK_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) rrPtr[s] <= '0;
    end else if (strobe.mainWr && !fillResident) begin
      if (rrPtr[fillSet] == WAY_W'(WAYS - 1)) rrPtr[fillSet] <= '0;
      else                                    rrPtr[fillSet] <= rrPtr[fillSet] + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_dp.sv
module tlb_dp
  import tlb_pkg::*;
#(
  parameter int VPN_W  = TLB_VPN_W,
  parameter int PPN_W  = TLB_PPN_W,
  parameter int ATTR_W = TLB_ATTR_W,
  parameter int SETS   = TLB_SETS,
  parameter int WAYS   = TLB_WAYS,
  parameter int LOCK_N = TLB_LOCK_N,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int LOCK_W = $clog2(LOCK_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  tlbStrobe_t        strobe,
  input  logic [WAY_W-1:0]  fillWay,
  input  logic [LOCK_W-1:0] lockIdx,
  input  logic              lookupValid,
  input  logic [VPN_W-1:0]  lookupVpn,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [PPN_W-1:0]  fillPpn,
  input  logic [ATTR_W-1:0] fillAttr,
  input  logic [VPN_W-1:0]  invVpn,
  output logic              fillResident,
  output logic [WAY_W-1:0]  fillResidentWay,
  output logic              respValid,
  output logic              respHit,
  output logic [PPN_W-1:0]  respPpn,
  output logic [ATTR_W-1:0] respAttr
);
  logic              mainValid [SETS][WAYS];
  logic [VPN_W-1:0]  mainTag   [SETS][WAYS];
  logic [PPN_W-1:0]  mainPpn   [SETS][WAYS];
  logic [ATTR_W-1:0] mainAttr  [SETS][WAYS];
  logic              lockValid [LOCK_N];
  logic [VPN_W-1:0]  lockTag   [LOCK_N];
  logic [PPN_W-1:0]  lockPpn   [LOCK_N];
  logic [ATTR_W-1:0] lockAttr  [LOCK_N];

  logic [SET_W-1:0] lkSet, fillSet, invSet;
  logic [WAYS-1:0]   lkMainHit, fillMainHit, invMainHit;
  logic [LOCK_N-1:0] lkLockHit, invLockHit;

  assign lkSet   = lookupVpn[SET_W-1:0];
  assign fillSet = fillVpn[SET_W-1:0];
  assign invSet  = invVpn[SET_W-1:0];

  for (genvar w = 0; w < WAYS; w++) begin : gWay
    assign lkMainHit[w]   = mainValid[lkSet][w]   && (mainTag[lkSet][w]   == lookupVpn);
    assign fillMainHit[w] = mainValid[fillSet][w] && (mainTag[fillSet][w] == fillVpn);
    assign invMainHit[w]  = mainValid[invSet][w]  && (mainTag[invSet][w]  == invVpn);
  end

  for (genvar i = 0; i < LOCK_N; i++) begin : gLock
    assign lkLockHit[i]  = lockValid[i] && (lockTag[i] == lookupVpn);
    assign invLockHit[i] = lockValid[i] && (lockTag[i] == invVpn);
  end

  // resident-way probe for fills (R4)
  always_comb begin
    fillResident    = |fillMainHit;
    fillResidentWay = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (fillMainHit[w]) fillResidentWay = WAY_W'(w);
  end

  // lookup select: pinned region overrides main region (R8)
  logic              lkHit;
  logic [PPN_W-1:0]  lkPpn;
  logic [ATTR_W-1:0] lkAttr;

  always_comb begin
    lkHit  = 1'b0;
    lkPpn  = '0;
    lkAttr = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (lkMainHit[w]) begin
        lkHit  = 1'b1;
        lkPpn  = mainPpn[lkSet][w];
        lkAttr = mainAttr[lkSet][w];
      end
    end
    for (int i = LOCK_N - 1; i >= 0; i--) begin
      if (lkLockHit[i]) begin
        lkHit  = 1'b1;
        lkPpn  = lockPpn[i];
        lkAttr = lockAttr[i];
      end
    end
  end

  // main-region valid bits (R1, R3, R6, R7)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) mainValid[s][w] <= 1'b0;
    end else if (strobe.clrAll) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) mainValid[s][w] <= 1'b0;
    end else begin
      if (strobe.clrOne)
        for (int w = 0; w < WAYS; w++)
          if (invMainHit[w]) mainValid[invSet][w] <= 1'b0;
      if (strobe.mainWr) mainValid[fillSet][fillWay] <= 1'b1;
    end
  end

  // pinned-region valid bits: untouched by clrAll (R6)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LOCK_N; i++) lockValid[i] <= 1'b0;
    end else begin
      if (strobe.clrOne)
        for (int i = 0; i < LOCK_N; i++)
          if (invLockHit[i]) lockValid[i] <= 1'b0;
      if (strobe.lockWr) lockValid[lockIdx] <= 1'b1;
    end
  end

  // payload storage, no reset needed behind the valid bits
  always_ff @(posedge clk) begin
    if (strobe.mainWr) begin
      mainTag[fillSet][fillWay]  <= fillVpn;
      mainPpn[fillSet][fillWay]  <= fillPpn;
      mainAttr[fillSet][fillWay] <= fillAttr;
    end
    if (strobe.lockWr) begin
      lockTag[lockIdx]  <= fillVpn;
      lockPpn[lockIdx]  <= fillPpn;
      lockAttr[lockIdx] <= fillAttr;
    end
  end

  // registered response (R2, R9)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respPpn   <= '0;
      respAttr  <= '0;
    end else begin
      respValid <= lookupValid;
      respHit   <= lookupValid && lkHit;
      respPpn   <= lookupValid ? lkPpn  : '0;
      respAttr  <= lookupValid ? lkAttr : '0;
    end
  end
endmodule

// File: rtl/tlb_lockdown.sv
module tlb_lockdown
  import tlb_pkg::*;
#(
  parameter int VPN_W  = TLB_VPN_W,
  parameter int PPN_W  = TLB_PPN_W,
  parameter int ATTR_W = TLB_ATTR_W,
  parameter int SETS   = TLB_SETS,
  parameter int WAYS   = TLB_WAYS,
  parameter int LOCK_N = TLB_LOCK_N,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int LOCK_W = $clog2(LOCK_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [VPN_W-1:0]  lookupVpn,
  input  logic              fillValid,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [PPN_W-1:0]  fillPpn,
  input  logic [ATTR_W-1:0] fillAttr,
  input  logic              cfgWrite,
  input  logic [LOCK_W:0]   cfgData,
  input  logic              invAll,
  input  logic              invOne,
  input  logic [VPN_W-1:0]  invVpn,
  output logic              respValid,
  output logic              respHit,
  output logic [PPN_W-1:0]  respPpn,
  output logic [ATTR_W-1:0] respAttr
);
  tlbStrobe_t        strobe;
  logic [WAY_W-1:0]  fillWay;
  logic [LOCK_W-1:0] lockIdx;
  logic              fillResident;
  logic [WAY_W-1:0]  fillResidentWay;

  tlb_ctrl #(.SETS(SETS), .WAYS(WAYS), .LOCK_N(LOCK_N)) uCtrl (
    .clk(clk), .rstN(rstN),
    .fillValid(fillValid), .fillSet(fillVpn[SET_W-1:0]),
    .invAll(invAll), .invOne(invOne),
    .cfgWrite(cfgWrite), .cfgData(cfgData),
    .fillResident(fillResident), .fillResidentWay(fillResidentWay),
    .strobe(strobe), .fillWay(fillWay), .lockIdx(lockIdx)
  );

  tlb_dp #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ATTR_W(ATTR_W),
           .SETS(SETS), .WAYS(WAYS), .LOCK_N(LOCK_N)) uDp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .fillWay(fillWay), .lockIdx(lockIdx),
    .lookupValid(lookupValid), .lookupVpn(lookupVpn),
    .fillVpn(fillVpn), .fillPpn(fillPpn), .fillAttr(fillAttr),
    .invVpn(invVpn),
    .fillResident(fillResident), .fillResidentWay(fillResidentWay),
    .respValid(respValid), .respHit(respHit),
    .respPpn(respPpn), .respAttr(respAttr)
  );
endmodule

// File: rtl/tlb_lockdown_chk.sv
module tlb_lockdown_chk #(
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int ATTR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              lookupValid,
  input logic [VPN_W-1:0]  lookupVpn,
  input logic              fillValid,
  input logic [VPN_W-1:0]  fillVpn,
  input logic              invAll,
  input logic              invOne,
  input logic [VPN_W-1:0]  invVpn,
  input logic              respValid,
  input logic              respHit,
  input logic [PPN_W-1:0]  respPpn,
  input logic [ATTR_W-1:0] respAttr
);
  p_resp_follows_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> respValid);

  p_no_resp_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !respValid);

  p_hit_needs_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    respHit |-> respValid);

  p_miss_is_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respHit) |-> (respPpn == '0 && respAttr == '0));

  p_fill_visible_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(fillValid && !invAll && !invOne) && lookupValid && lookupVpn == $past(fillVpn))
      |=> respHit);

  p_flush_one_gone_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(invOne) && lookupValid && lookupVpn == $past(invVpn)) |=> !respHit);
endmodule

bind tlb_lockdown tlb_lockdown_chk #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ATTR_W(ATTR_W)) uChk (
  .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVpn(lookupVpn),
  .fillValid(fillValid), .fillVpn(fillVpn), .invAll(invAll), .invOne(invOne),
  .invVpn(invVpn), .respValid(respValid), .respHit(respHit),
  .respPpn(respPpn), .respAttr(respAttr)
);

// File: tb/tlb_lockdown_test.sv
`timescale 1ns/100ps
module tlb_lockdown_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        lookupValid, fillValid, cfgWrite, invAll, invOne;
  logic [19:0] lookupVpn, fillVpn, invVpn, fillPpn;
  logic [7:0]  fillAttr;
  logic [3:0]  cfgData;
  logic        respValid, respHit;
  logic [19:0] respPpn;
  logic [7:0]  respAttr;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  tlb_lockdown uut (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVpn(lookupVpn),
    .fillValid(fillValid), .fillVpn(fillVpn), .fillPpn(fillPpn), .fillAttr(fillAttr),
    .cfgWrite(cfgWrite), .cfgData(cfgData), .invAll(invAll), .invOne(invOne),
    .invVpn(invVpn), .respValid(respValid), .respHit(respHit),
    .respPpn(respPpn), .respAttr(respAttr)
  );

  localparam logic [2:0] OP_CFG = 3'd1, OP_FILL = 3'd2, OP_INVALL = 3'd3,
                         OP_INVONE = 3'd4, OP_LOOK = 3'd5;

  typedef struct packed {
    logic [2:0]  op;
    logic [19:0] vpn;
    logic [19:0] ppn;   // fill data, or expected page on lookup
    logic [7:0]  attr;  // fill data, expected attr, or cfg value
    logic        hit;   // expected hit on lookup
    logic [7:0]  req;   // requirement number printed on failure
  } vec_t;

  localparam int NV = 38;
  localparam vec_t VT [NV] = '{
    '{OP_LOOK,   20'h00012, 20'h00000, 8'h00, 1'b0, 8'd1},  // R1 empty
    '{OP_FILL,   20'h00012, 20'hAAAA1, 8'h11, 1'b0, 8'd0},
    '{OP_LOOK,   20'h00012, 20'hAAAA1, 8'h11, 1'b1, 8'd2},  // R2
    '{OP_LOOK,   20'h00022, 20'h00000, 8'h00, 1'b0, 8'd9},  // R9 same set, other tag
    '{OP_FILL,   20'h00022, 20'hBBBB2, 8'h22, 1'b0, 8'd0},
    '{OP_FILL,   20'h00032, 20'hCCCC3, 8'h33, 1'b0, 8'd0},  // evicts 00012
    '{OP_LOOK,   20'h00012, 20'h00000, 8'h00, 1'b0, 8'd3},  // R3
    '{OP_LOOK,   20'h00022, 20'hBBBB2, 8'h22, 1'b1, 8'd3},
    '{OP_LOOK,   20'h00032, 20'hCCCC3, 8'h33, 1'b1, 8'd3},
    '{OP_FILL,   20'h00032, 20'hDDDD4, 8'h44, 1'b0, 8'd0},  // refill resident page
    '{OP_LOOK,   20'h00022, 20'hBBBB2, 8'h22, 1'b1, 8'd4},  // R4 neighbour kept
    '{OP_LOOK,   20'h00032, 20'hDDDD4, 8'h44, 1'b1, 8'd4},
    '{OP_FILL,   20'h00005, 20'h11115, 8'h05, 1'b0, 8'd0},
    '{OP_LOOK,   20'h00005, 20'h11115, 8'h05, 1'b1, 8'd3},  // R3 other set
    '{OP_CFG,    20'h00000, 20'h00000, 8'h0B, 1'b0, 8'd0},  // pin, slot 3
    '{OP_FILL,   20'h12345, 20'h77777, 8'h77, 1'b0, 8'd0},
    '{OP_LOOK,   20'h12345, 20'h77777, 8'h77, 1'b1, 8'd5},  // R5
    '{OP_FILL,   20'h00022, 20'h88888, 8'h88, 1'b0, 8'd0},  // slot 3 again
    '{OP_LOOK,   20'h12345, 20'h00000, 8'h00, 1'b0, 8'd5},  // R5 replaced
    '{OP_LOOK,   20'h00022, 20'h88888, 8'h88, 1'b1, 8'd8},  // R8 pinned wins
    '{OP_CFG,    20'h00000, 20'h00000, 8'h0E, 1'b0, 8'd0},  // pin, slot 6
    '{OP_FILL,   20'h0ABCD, 20'h66666, 8'h66, 1'b0, 8'd0},
    '{OP_CFG,    20'h00000, 20'h00000, 8'h00, 1'b0, 8'd0},
    '{OP_INVALL, 20'h00000, 20'h00000, 8'h00, 1'b0, 8'd0},
    '{OP_LOOK,   20'h00032, 20'h00000, 8'h00, 1'b0, 8'd6},  // R6 main gone
    '{OP_LOOK,   20'h00005, 20'h00000, 8'h00, 1'b0, 8'd6},
    '{OP_LOOK,   20'h0ABCD, 20'h66666, 8'h66, 1'b1, 8'd6},  // R6 pinned kept
    '{OP_LOOK,   20'h00022, 20'h88888, 8'h88, 1'b1, 8'd6},
    '{OP_INVONE, 20'h0ABCD, 20'h00000, 8'h00, 1'b0, 8'd0},
    '{OP_LOOK,   20'h0ABCD, 20'h00000, 8'h00, 1'b0, 8'd7},  // R7 pinned removed
    '{OP_LOOK,   20'h00022, 20'h88888, 8'h88, 1'b1, 8'd7},
    '{OP_FILL,   20'h00077, 20'h12121, 8'h21, 1'b0, 8'd0},
    '{OP_LOOK,   20'h00077, 20'h12121, 8'h21, 1'b1, 8'd11}, // R11
    '{OP_INVALL, 20'h00000, 20'h00000, 8'h00, 1'b0, 8'd0},
    '{OP_LOOK,   20'h00077, 20'h00000, 8'h00, 1'b0, 8'd11}, // went to main
    '{OP_FILL,   20'h00022, 20'h99999, 8'h99, 1'b0, 8'd0},
    '{OP_INVONE, 20'h00022, 20'h00000, 8'h00, 1'b0, 8'd0},
    '{OP_LOOK,   20'h00022, 20'h00000, 8'h00, 1'b0, 8'd7}   // R7 both regions
  };

  task automatic idleInputs();
    lookupValid = 1'b0; lookupVpn = '0;
    fillValid = 1'b0; fillVpn = '0; fillPpn = '0; fillAttr = '0;
    cfgWrite = 1'b0; cfgData = '0;
    invAll = 1'b0; invOne = 1'b0; invVpn = '0;
  endtask

  task automatic checkVal(input int req, input string what, input logic [31:0] act,
                          input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, sample at the next falling edge
  task automatic look(input logic [19:0] vpn, input logic expHit, input logic [19:0] expPpn,
                      input logic [7:0] expAttr, input int req);
    lookupValid = 1'b1; lookupVpn = vpn;
    @(negedge clk);
    idleInputs();
    checkVal(req, "respValid", 32'(respValid), 32'd1);
    checkVal(req, "respHit",   32'(respHit),   32'(expHit));
    checkVal(req, "respPpn",   32'(respPpn),   32'(expPpn));
    checkVal(req, "respAttr",  32'(respAttr),  32'(expAttr));
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic [7:0] attr);
    fillValid = 1'b1; fillVpn = vpn; fillPpn = ppn; fillAttr = attr;
    @(negedge clk);
    idleInputs();
  endtask

  task automatic cfg(input logic [3:0] val);
    cfgWrite = 1'b1; cfgData = val;
    @(negedge clk);
    idleInputs();
  endtask

  task automatic flushAll();
    invAll = 1'b1;
    @(negedge clk);
    idleInputs();
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idleInputs();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    checkVal(1, "respValid in reset", 32'(respValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    checkVal(1, "respValid after reset", 32'(respValid), 32'd0);

    for (int k = 0; k < NV; k++) begin
      case (VT[k].op)
        OP_CFG:    cfg(VT[k].attr[3:0]);
        OP_FILL:   fill(VT[k].vpn, VT[k].ppn, VT[k].attr);
        OP_INVALL: flushAll();
        OP_INVONE: begin
          invOne = 1'b1; invVpn = VT[k].vpn;
          @(negedge clk);
          idleInputs();
        end
        OP_LOOK:   look(VT[k].vpn, VT[k].hit, VT[k].ppn, VT[k].attr, int'(VT[k].req));
        default:   @(negedge clk);
      endcase
    end

    // R10: fill together with flush-all is dropped
    fillValid = 1'b1; fillVpn = 20'h00055; fillPpn = 20'h55555; fillAttr = 8'h55;
    invAll = 1'b1;
    @(negedge clk);
    idleInputs();
    look(20'h00055, 1'b0, 20'h0, 8'h0, 10);

    // R10: pinned fill together with flush-one of another page is dropped
    cfg(4'b1000);
    fillValid = 1'b1; fillVpn = 20'h00066; fillPpn = 20'h66600; fillAttr = 8'h60;
    invOne = 1'b1; invVpn = 20'h00999;
    @(negedge clk);
    idleInputs();
    look(20'h00066, 1'b0, 20'h0, 8'h0, 10);

    // pinned slot 0 now filled, then reset clears it (R1)
    fill(20'h00066, 20'h66600, 8'h60);
    look(20'h00066, 1'b1, 20'h66600, 8'h60, 5);
    rstN = 1'b0;
    @(negedge clk);
    checkVal(1, "respValid after mid reset", 32'(respValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    look(20'h00066, 1'b0, 20'h0, 8'h0, 1);

    // R1/R11: pin flag back to 0 after reset, so this fill is flushable
    fill(20'h00088, 20'h88800, 8'h80);
    look(20'h00088, 1'b1, 20'h88800, 8'h80, 11);
    flushAll();
    look(20'h00088, 1'b0, 20'h0, 8'h0, 11);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule